// File: doc/BRIEF.md
# SDRAM Command Front-End Decoder

This block is the input stage on the device side of a synchronous DRAM. On every rising clock edge it samples the clock-enable, chip-select, row-strobe, column-strobe and write-enable pins, together with the bank and address inputs. It turns them into a registered, single-cycle command strobe with an enumerated command code, a bank index, a row or column address and a separate variant flag taken from address bit 10. The bank state machines further down the chip use these outputs.

Clock enable works one cycle late. The level sampled at one edge decides whether the next edge does any work. The block brings out that internal advance enable, and also a latency tick that the burst and CAS-latency counters downstream use as their count enable. While the clock is masked, no command is decoded and the tick stays low. A deselected chip always decodes as NOP.

Top module: `sdram_cmd_front`

## Requirements
- R1: While `rst_n` is low, `cmd_vld`, `lat_tick`, `op_en` and `a10_flag` are 0, `cmd_code` is NOP (3'b111), and `bank_idx` and `addr_out` are 0.
- R2: After each rising edge, `op_en` equals the `cke` level sampled at that edge. Reset clears it to 0.
- R3: An edge is active only if `op_en` was high before it. At a masked edge, the outputs after the edge show NOP, `cmd_vld`=0 and `lat_tick`=0, whatever the control pins carry.
- R4: `lat_tick` is high for exactly one cycle after each active edge, and low after each masked edge.
- R5: When `cs_n` is high at an active edge, the result is NOP with `cmd_vld`=0. The other inputs have no effect.
- R6: At an active edge with `cs_n` low, `cmd_code` takes the active-low pin code {ras_n,cas_n,we_n}: 111 NOP, 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE-LOAD, 110 BURST-STOP.
- R7: `cmd_vld` is high for the one cycle after an active edge that decoded a command other than NOP, and low at every other time.
- R8: `bank_idx` carries the bank inputs for ACTIVATE, READ, WRITE, PRECHARGE and MODE-LOAD, and is 0 for every other command. With `NUM_BANKS`=4 it is {ba[1],ba[0]}. With `NUM_BANKS`=2 it is ba[0] alone.
- R9: `addr_out` is the full address for ACTIVATE and MODE-LOAD. For READ and WRITE it is the column address, which is the address with bit 10 cleared. For every other command it is 0.
- R10: `a10_flag` equals address bit 10 for READ, WRITE, PRECHARGE, REFRESH and BURST-STOP, and is 0 for every other command.
- R11: Once `cke` is sampled high after a masked period, the next edge decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | 2 | Bank address pins |
| addr | input | ADDR_W | Address pins; bit 10 is the variant bit |
| op_en | output | 1 | Internal advance enable for the next edge |
| lat_tick | output | 1 | Latency counter count enable |
| cmd_vld | output | 1 | Single-cycle strobe for a decoded command |
| cmd_code | output | 3 | Decoded command code |
| bank_idx | output | BANK_W | Target bank |
| addr_out | output | ADDR_W | Row, column or mode address |
| a10_flag | output | 1 | Variant flag from address bit 10 |

## Verification
The hardest case to reach is a real command that arrives at the edge just after `cke` was sampled low. That command must leave no trace, while the command at the edge where `cke` fell must still decode normally. A directed sequence drops `cke` while an ACTIVATE is on the pins, holds another ACTIVATE at the masked edge, raises `cke` with a READ that is still masked, and then expects the following READ to decode. A long random run also toggles `cke` about one edge in five, so that masked edges land against every command type.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  localparam int unsigned VARIANT_BIT = 10;

  // commands that address a bank
  function automatic logic cmd_has_bank(cmd_e c);
    return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) ||
           (c == CMD_PRE) || (c == CMD_LMR);
  endfunction

  // commands with no address or a column address: variant bit applies
  function automatic logic cmd_has_variant(cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR) || (c == CMD_PRE) ||
           (c == CMD_REF) || (c == CMD_BST);
  endfunction

  function automatic logic cmd_full_addr(cmd_e c);
    return (c == CMD_ACT) || (c == CMD_LMR);
  endfunction

  function automatic logic cmd_col_addr(cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/cke_mask_stage.sv
module cke_mask_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic op_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_en <= 1'b0;
    else        op_en <= cke;
  end

  // R11
  resume_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> op_en);
endmodule

// File: rtl/latency_tick_gen.sv
module latency_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic op_en,
  output logic lat_tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_tick <= 1'b0;
    else        lat_tick <= op_en;
  end

  // R3
  tick_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> !lat_tick);
endmodule

// File: rtl/cmd_decode_stage.sv
module cmd_decode_stage
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = (NUM_BANKS > 2) ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank_idx,
  output logic [ADDR_W-1:0] addr_out,
  output logic              a10_flag
);
  localparam logic [ADDR_W-1:0] COL_MASK = ~(ADDR_W'(1) << VARIANT_BIT);

  logic              live_edge;
  cmd_e              cur_cmd;
  logic [BANK_W-1:0] bank_sel;
  logic [BANK_W-1:0] bank_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              a10_nxt;

  generate
    if (NUM_BANKS > 2) begin : g_four_banks
      assign bank_sel = ba;
    end else begin : g_two_banks
      assign bank_sel = ba[0];
    end
  endgenerate

  assign live_edge = op_en && !cs_n;

  always_comb begin
    cur_cmd = live_edge ? cmd_e'({ras_n, cas_n, we_n}) : CMD_NOP;
    bank_nxt = cmd_has_bank(cur_cmd) ? bank_sel : '0;
    if (cmd_full_addr(cur_cmd))     addr_nxt = addr;
    else if (cmd_col_addr(cur_cmd)) addr_nxt = addr & COL_MASK;
    else                            addr_nxt = '0;
    a10_nxt = cmd_has_variant(cur_cmd) ? addr[VARIANT_BIT] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd      <= CMD_NOP;
      bank_idx <= '0;
      addr_out <= '0;
      a10_flag <= 1'b0;
    end else begin
      cmd_vld  <= (cur_cmd != CMD_NOP);
      cmd      <= cur_cmd;
      bank_idx <= bank_nxt;
      addr_out <= addr_nxt;
      a10_flag <= a10_nxt;
    end
  end

  // R3
  vld_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> !cmd_vld && (cmd == CMD_NOP));
  // R5
  deselect_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !cmd_vld && (cmd == CMD_NOP));
  // R7
  vld_not_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd != CMD_NOP));
  // R10
  a10_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a10_flag |-> cmd_has_variant(cmd));
  // R9
  col_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col_addr(cmd) |-> !addr_out[VARIANT_BIT]);
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W   = (NUM_BANKS > 2) ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              op_en,
  output logic              lat_tick,
  output logic              cmd_vld,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] bank_idx,
  output logic [ADDR_W-1:0] addr_out,
  output logic              a10_flag
);
  cmd_e dec_cmd;

  cke_mask_stage i_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .op_en (op_en)
  );

  latency_tick_gen i_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .lat_tick (lat_tick)
  );

  cmd_decode_stage #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS)
  ) i_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_en    (op_en),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr),
    .cmd_vld  (cmd_vld),
    .cmd      (dec_cmd),
    .bank_idx (bank_idx),
    .addr_out (addr_out),
    .a10_flag (a10_flag)
  );

  assign cmd_code = dec_cmd;

  // R4
  tick_per_live_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> lat_tick);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !cmd_vld && !lat_tick && !op_en);
endmodule

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;
  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic op_en, lat_tick, cmd_vld, a10_flag;
  logic [2:0] cmd_code;
  logic [BANK_W-1:0] bank_idx;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic mq = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_front #(.ADDR_W(ADDR_W), .NUM_BANKS(4)) i_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .op_en(op_en),
    .lat_tick(lat_tick), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .bank_idx(bank_idx), .addr_out(addr_out), .a10_flag(a10_flag)
  );

  function automatic logic [2:0] m_cmd(logic en, logic c, logic [2:0] pins);
    if (!en || c) return 3'b111;
    return pins;
  endfunction
  function automatic logic [1:0] m_bank(logic [2:0] k, logic [1:0] b);
    case (k)
      3'b011, 3'b101, 3'b100, 3'b010, 3'b000: return b;
      default: return 2'b00;
    endcase
  endfunction
  function automatic logic [ADDR_W-1:0] m_addr(logic [2:0] k, logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] col;
    col = a;
    col[10] = 1'b0;
    case (k)
      3'b011, 3'b000: return a;
      3'b101, 3'b100: return col;
      default: return '0;
    endcase
  endfunction
  function automatic logic m_a10(logic [2:0] k, logic [ADDR_W-1:0] a);
    case (k)
      3'b101, 3'b100, 3'b010, 3'b001, 3'b110: return a[10];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // apply at a negedge, let one posedge pass, compare at the next negedge
  task automatic step(input logic k, input logic c, input logic [2:0] pins,
                      input logic [1:0] b, input logic [ADDR_W-1:0] a,
                      input string ctx);
    logic en;
    logic [2:0] ek;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    en = mq;
    mq = k;
    ek = m_cmd(en, c, pins);
    @(negedge clk);
    chk(op_en == k, {ctx, " R2 op_en"}, op_en, k);
    chk(lat_tick == en, {ctx, en ? " R4 tick" : " R3 tick frozen"}, lat_tick, en);
    chk(cmd_code == ek, {ctx, " R6 cmd"}, cmd_code, ek);
    chk(cmd_vld == (ek != 3'b111), {ctx, " R7 vld"}, cmd_vld, ek != 3'b111);
    chk(bank_idx == m_bank(ek, b), {ctx, " R8 bank"}, bank_idx, m_bank(ek, b));
    chk(addr_out == m_addr(ek, a), {ctx, " R9 addr"}, addr_out, m_addr(ek, a));
    chk(a10_flag == m_a10(ek, a), {ctx, " R10 a10"}, a10_flag, m_a10(ek, a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmd_vld && !lat_tick && !op_en && !a10_flag, "R1 reset flags",
        {cmd_vld, lat_tick, op_en, a10_flag}, 0);
    chk(cmd_code == 3'b111 && bank_idx == 0 && addr_out == 0, "R1 reset values",
        cmd_code, 3'b111);
    rst_n = 1'b1;
    mq = 1'b0;
    // first edge after reset is masked even with CKE high
    step(1, 0, 3'b011, 2'd1, 13'h0123, "post-reset R3");
    step(1, 0, 3'b011, 2'd2, 13'h1abc, "activate");
    step(1, 0, 3'b101, 2'd3, 13'h0455, "read a10");
    step(1, 0, 3'b100, 2'd0, 13'h0055, "write");
    step(1, 0, 3'b010, 2'd1, 13'h0400, "precharge all");
    step(1, 0, 3'b001, 2'd2, 13'h07ff, "refresh");
    step(1, 0, 3'b000, 2'd3, 13'h0033, "mode load");
    step(1, 0, 3'b110, 2'd1, 13'h0400, "burst stop");
    // CKE drops: this edge still works, next is masked
    step(0, 0, 3'b011, 2'd2, 13'h0111, "cke fall edge");
    step(0, 0, 3'b011, 2'd3, 13'h0222, "masked cmd R3");
    step(1, 0, 3'b101, 2'd1, 13'h0333, "cke rise still masked R3");
    step(1, 0, 3'b101, 2'd1, 13'h0444, "resume R11");
    // R5 deselect
    step(1, 1, 3'b100, 2'd3, 13'h1fff, "deselect R5");
    step(1, 0, 3'b111, 2'd3, 13'h1fff, "explicit nop");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] pins;
      pins = 3'($urandom);
      step(($urandom % 5) != 0, ($urandom % 5) == 0, pins,
           2'($urandom), ADDR_W'($urandom), "random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule